// File: doc/BRIEF.md
# Serial EEPROM command controller

This block is the slave end of a four-wire serial bus (chip select, clock, data in, data out) placed in front of a 512-byte memory. The memory is held in on-chip registers. A host selects the block, shifts in an instruction byte, and then sends the address and data bytes or reads bytes back. All bus pins pass through a two-flop synchronizer into the system clock domain. The serial clock must therefore run well below the system clock.

Three gates guard every nonvolatile update, and all three must be open:

- a write-enable latch that software sets and clears;
- an active-low protect pin;
- a pair of guard bits in the status register that fence off a quarter, a half or all of the array.

An update takes effect only when chip select is released cleanly on a byte boundary. The update then runs a self-timed write cycle. During that cycle the status register shows busy, and every instruction except the status read is ignored.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: `sdo_en_o` is low whenever the synchronized chip select is high. `sdo_o` changes only after a falling edge of `sck_i`, and bytes go out MSB first.
- R2: After reset the status register reads 00h. No instruction is accepted until chip select has gone from high to low after reset. Clocking a byte while chip select was already low at reset has no effect.
- R3: Instruction 06h sets the write-enable latch and 04h clears it. The latch is status bit 1.
- R4: Read is 03h with address bit 8 carried in bit 3 of the instruction byte (so 0Bh reads the upper half), followed by the low address byte. Bytes then stream from consecutive addresses for as long as the clock runs, wrapping from 1FFh to 000h.
- R5: Write is 02h, with address bit 8 in bit 3 of the instruction byte (0Ah for the upper half), followed by the low address byte and up to 16 data bytes. The low four address bits wrap within the 16-byte page. A 17th or later byte overwrites the buffered byte at its wrapped position.
- R6: A write or status update starts only if chip select rises with zero stray bits after the last whole byte and at least one data byte was received. Otherwise it is discarded, and the array, the busy flag and the latch are unchanged.
- R7: A write or status update is discarded if the latch is clear or if `wprot_ni` is low when chip select rises.
- R8: Status bits 3:2 guard the array as follows. The guarded region is where array writes are discarded; reads are unaffected.

  | Bits 3:2 | Guarded region |
  |---|---|
  | 00 | none |
  | 01 | 180h–1FFh |
  | 10 | 100h–1FFh |
  | 11 | the whole array |
- R9: A falling edge of `wprot_ni` while chip select is low cancels the pending write, even if the pin returns high before chip select rises. Once the write cycle has started, `wprot_ni` has no effect on it.
- R10: An accepted update sets status bit 0 (busy) for `WRITE_CYCLES` clock cycles. While busy, only the status read 05h is honoured, and all other instructions are ignored. When the cycle ends, busy and the latch both clear.
- R11: Instruction 01h followed by one data byte writes status bits 3:2 and 5:4 from the same bits of that byte. It is gated as in R6 and R7, is not subject to R8, and runs a write cycle as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, sampled on the rising edge of `sck_i` |
| wprot_ni | input | 1 | Write protect, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for `sdo_o`; low means high impedance |

## Verification
The assertions check the following on every cycle:

- a write cycle only ever starts with the latch set and the protect pin high;
- the latch is clear when busy drops;
- no new write cycle starts while one runs;
- an instruction other than the status read decoded during busy leaves no command active;
- the output bit holds still except after a serial clock fall.

The bench scenarios are needed for everything that depends on data:

- address bit 8 travelling in the instruction byte;
- wrap of a streaming read across the end of the array and wrap within a page;
- overwrite of buffered bytes;
- discard on a stray bit count or on an empty write;
- cancellation by a protect-pin pulse;
- each of the guard regions.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam logic [7:0] OPC_SET_WE  = 8'h06;
  localparam logic [7:0] OPC_CLR_WE  = 8'h04;
  localparam logic [7:0] OPC_STAT_RD = 8'h05;
  localparam logic [7:0] OPC_STAT_WR = 8'h01;
  localparam logic [7:0] OPC_READ    = 8'h03;
  localparam logic [7:0] OPC_WRITE   = 8'h02;
  localparam logic [7:0] HI_ADDR_MSK = 8'hF7;  // bit 3 carries address bit 8

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_STAT_RD, CMD_STAT_WR
  } cmd_e;
endpackage

// File: rtl/spi_sampler.sv
module spi_sampler #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pins_i;
      sync2_q <= sync1_q;
    end
  end

  assign level_o = sync2_q;
endmodule

// File: rtl/wr_timer.sv
module wr_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (done_o) busy_o <= 1'b0;
      else        cnt_q  <= cnt_q + CW'(1);
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign done_o = busy_o && (cnt_q == CW'(CYCLES - 1));

  // R10: a running cycle is never restarted
  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 512,
  parameter int PAGE  = 16
) (
  input  logic                       clk_i,
  input  logic                       commit_i,
  input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_i,
  input  logic [PAGE*8-1:0]          data_i,
  input  logic [PAGE-1:0]            mask_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr_i,
  output logic [7:0]                 rd_data_o
);
  localparam int PW = $clog2(PAGE);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE; i++) begin
        if (mask_i[i]) mem[{page_i, PW'(i)}] <= data_i[i*8 +: 8];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int DEPTH        = 512,
  parameter int PAGE         = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic wprot_ni,
  output logic sdo_o,
  output logic sdo_en_o
);
  localparam int AW = $clog2(DEPTH);  // needs AW >= 9
  localparam int PW = $clog2(PAGE);

  logic [3:0] lvl;
  logic [2:0] prev_q;  // {wp, sck, cs}
  logic cs_dn, cs_up, sck_up, sck_dn, wp_dn, wp_ok, sdi;

  spi_sampler #(.W(4)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pins_i({wprot_ni, sdi_i, sck_i, cs_ni}), .level_o(lvl)
  );

  assign cs_dn  =  prev_q[0] & ~lvl[0];
  assign cs_up  = ~prev_q[0] &  lvl[0];
  assign sck_up = ~prev_q[1] &  lvl[1];
  assign sck_dn =  prev_q[1] & ~lvl[1];
  assign wp_dn  =  prev_q[2] & ~lvl[3];
  assign sdi    = lvl[2];
  assign wp_ok  = lvl[3];

  logic            active, wel, seen, cancel, sdo_q;
  logic [2:0]      bit_cnt;
  logic [1:0]      byte_cnt, guard, wd;
  logic [6:0]      sh;
  logic [7:0]      out_sh, cur, status, rd_data;
  logic [3:0]      stat_new;
  logic [AW-1:0]   addr, rd_addr;
  logic [PAGE*8-1:0] pbuf;
  logic [PAGE-1:0] pmask;
  cmd_e            cmd;
  logic            busy, done, gate, prot_hit, start_wr, start_sr, byte_end;

  assign cur      = {sh, sdi};
  assign status   = {2'b00, wd, guard, wel, busy};
  assign byte_end = active && !cs_up && !cs_dn && sck_up && (bit_cnt == 3'd7);
  assign rd_addr  = (byte_cnt == 2'd1) ? {addr[AW-1:8], cur} : addr;

  always_comb begin
    unique case (guard)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = &addr[AW-1:AW-2];
      2'b10:   prot_hit = addr[AW-1];
      default: prot_hit = 1'b1;
    endcase
  end

  assign gate     = active && cs_up && (bit_cnt == 3'd0) && seen && wel &&
                    wp_ok && !cancel && !busy;
  assign start_wr = gate && (cmd == CMD_WRITE) && !prot_hit;
  assign start_sr = gate && (cmd == CMD_STAT_WR);

  wr_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_wr | start_sr),
    .busy_o(busy), .done_o(done)
  );

  eeprom_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_arr (
    .clk_i(clk_i), .commit_i(start_wr), .page_i(addr[AW-1:PW]),
    .data_i(pbuf), .mask_i(pmask), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0; active <= 1'b0; wel <= 1'b0; seen <= 1'b0; cancel <= 1'b0;
      sdo_q <= 1'b0; bit_cnt <= '0; byte_cnt <= '0; guard <= '0; wd <= '0;
      sh <= '0; out_sh <= '0; stat_new <= '0; addr <= '0; pbuf <= '0;
      pmask <= '0; cmd <= CMD_NONE;
    end else begin
      prev_q <= {lvl[3], lvl[1], lvl[0]};
      if (done) wel <= 1'b0;
      if (start_sr) begin
        guard <= stat_new[1:0];
        wd    <= stat_new[3:2];
      end
      if (cs_dn) begin
        active <= 1'b1; bit_cnt <= '0; byte_cnt <= '0; cmd <= CMD_NONE;
        seen <= 1'b0; cancel <= 1'b0; pmask <= '0;
      end else if (cs_up) begin
        active <= 1'b0;
      end else if (active) begin
        if (wp_dn) cancel <= 1'b1;
        if (sck_dn) begin
          sdo_q  <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
        if (sck_up) begin
          sh      <= cur[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_end) begin
          if (byte_cnt != 2'd2) byte_cnt <= byte_cnt + 2'd1;
          if (byte_cnt == 2'd0) begin
            if (cur == OPC_STAT_RD) begin
              cmd <= CMD_STAT_RD; out_sh <= status;
            end else if (!busy) begin
              if (cur == OPC_SET_WE)       wel <= 1'b1;
              else if (cur == OPC_CLR_WE)  wel <= 1'b0;
              else if (cur == OPC_STAT_WR) cmd <= CMD_STAT_WR;
              else if ((cur & HI_ADDR_MSK) == OPC_READ) begin
                cmd <= CMD_READ;  addr[AW-1:8] <= (AW-8)'(cur[3]);
              end else if ((cur & HI_ADDR_MSK) == OPC_WRITE) begin
                cmd <= CMD_WRITE; addr[AW-1:8] <= (AW-8)'(cur[3]);
              end
            end
          end else begin
            case (cmd)
              CMD_READ: begin
                out_sh <= rd_data;
                addr   <= rd_addr + AW'(1);
              end
              CMD_WRITE: begin
                if (byte_cnt == 2'd1) addr[7:0] <= cur;
                else begin
                  pbuf[{addr[PW-1:0], 3'b000} +: 8] <= cur;
                  pmask[addr[PW-1:0]] <= 1'b1;
                  addr[PW-1:0] <= addr[PW-1:0] + PW'(1);
                  seen <= 1'b1;
                end
              end
              CMD_STAT_WR: if (byte_cnt == 2'd1) begin
                stat_new <= cur[5:2];
                seen     <= 1'b1;
              end
              CMD_STAT_RD: out_sh <= status;
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = active;

  // R7: a cycle only starts from an open latch and a high protect pin
  assert_start_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(wel) && $past(wp_ok)));
  // R10: the latch is clear when the cycle ends
  assert_wel_cleared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel);
  // R10: only the status read survives decode while busy
  assert_busy_decode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && byte_end && byte_cnt == 2'd0 && cur != OPC_STAT_RD) |=> cmd == CMD_NONE);
  // R1: output bit moves only after a serial clock fall
  assert_sdo_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_dn |=> $stable(sdo_q));
endmodule

// File: tb/spi_eeprom_ctrl_test.sv
`timescale 1ns/100ps
module spi_eeprom_ctrl_test;
  localparam int WC = 600;
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {9'h000, 8'h3C}, {9'h0FF, 8'hA5}, {9'h100, 8'h5A}, {9'h17F, 8'hC3},
    {9'h180, 8'h96}, {9'h1FF, 8'h69}, {9'h055, 8'h12}, {9'h1A3, 8'hE7}};

  logic clk = 0, rst_n = 0, cs_n = 0, sck = 0, sdi = 0, wp_n = 1;
  logic sdo, sdo_en;
  int checks = 0, errors = 0;
  logic [7:0] model [512];
  logic [7:0] wdat [20];
  logic [7:0] rbuf [4];
  logic [7:0] st, dummy;

  always #2.5 clk = ~clk;

  spi_eeprom_ctrl #(.WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .wprot_ni(wp_n), .sdo_o(sdo), .sdo_en_o(sdo_en));

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i]; wclk(4); rx[i] = sdo; sck = 1; wclk(4); sck = 0;
    end
  endtask

  task automatic sel;   cs_n = 0; wclk(8); endtask
  task automatic desel; wclk(4); cs_n = 1; wclk(8); endtask
  task automatic cmd1(logic [7:0] op); sel(); xfer(op, dummy); desel(); endtask
  task automatic wait_done; wclk(WC + 50); endtask

  task automatic rd_stat(output logic [7:0] s);
    sel(); xfer(8'h05, dummy); xfer(8'h00, s); desel();
  endtask

  task automatic rd_mem(logic [8:0] a, int n);
    sel(); xfer({4'b0000, a[8], 3'b011}, dummy); xfer(a[7:0], dummy);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
    desel();
  endtask

  task automatic wr_mem(logic [8:0] a, int n, int extra);
    sel(); xfer({4'b0000, a[8], 3'b010}, dummy); xfer(a[7:0], dummy);
    for (int k = 0; k < n; k++) xfer(wdat[k], dummy);
    for (int k = 0; k < extra; k++) begin
      sdi = 1; wclk(4); sck = 1; wclk(4); sck = 0;
    end
    desel();
  endtask

  task automatic set_stat(logic [7:0] v);
    cmd1(8'h06); sel(); xfer(8'h01, dummy); xfer(v, dummy); desel(); wait_done();
  endtask

  task automatic try_wr(logic [8:0] a, logic [7:0] d, bit ok, string tag);
    cmd1(8'h06); wdat[0] = d; wr_mem(a, 1, 0); wait_done();
    cmd1(8'h04);
    if (ok) model[a] = d;
    rd_mem(a, 1); chk(rbuf[0], model[a], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wclk(5); rst_n = 1; wclk(4);
    chk(sdo_en, 0, "R1 output off after reset");
    xfer(8'h06, dummy);               // chip select never fell
    cs_n = 1; wclk(8);
    rd_stat(st); chk(st, 8'h00, "R2 no command before first select");

    cmd1(8'h06); rd_stat(st); chk(st, 8'h02, "R3 latch set");
    sel(); chk(sdo_en, 1, "R1 output on while selected"); desel();
    chk(sdo_en, 0, "R1 output off after deselect");
    cmd1(8'h04); rd_stat(st); chk(st, 8'h00, "R3 latch cleared");

    for (int v = 0; v < NV; v++) begin
      cmd1(8'h06); wdat[0] = VEC[v][7:0]; wr_mem(VEC[v][16:8], 1, 0);
      model[VEC[v][16:8]] = VEC[v][7:0]; wait_done();
    end
    for (int v = 0; v < NV; v++) begin
      rd_mem(VEC[v][16:8], 1); chk(rbuf[0], VEC[v][7:0], "R4 R5 table readback");
    end

    rd_mem(9'h1FF, 2);
    chk(rbuf[0], model[9'h1FF], "R4 stream at end");
    chk(rbuf[1], model[9'h000], "R4 stream wraps to zero");
    rd_mem(9'h0FF, 2);
    chk(rbuf[1], model[9'h100], "R4 stream into upper half");

    cmd1(8'h06);
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h44;
    wr_mem(9'h12E, 4, 0);
    model[9'h12E] = 8'h11; model[9'h12F] = 8'h22;
    model[9'h120] = 8'h33; model[9'h121] = 8'h44;
    rd_stat(st); chk(st, 8'h03, "R10 busy after commit");
    cmd1(8'h04);
    rd_stat(st); chk(st, 8'h03, "R10 latch clear ignored while busy");
    wait_done();
    rd_stat(st); chk(st, 8'h00, "R10 busy and latch clear at end");
    rd_mem(9'h120, 2);
    chk(rbuf[0], 8'h33, "R5 page wrap first"); chk(rbuf[1], 8'h44, "R5 page wrap second");
    rd_mem(9'h12E, 2);
    chk(rbuf[0], 8'h11, "R5 page start"); chk(rbuf[1], 8'h22, "R5 page end");

    cmd1(8'h06);
    for (int k = 0; k < 18; k++) begin
      wdat[k] = 8'hA0 + 8'(k);
      model[9'h130 + 9'(k % 16)] = 8'hA0 + 8'(k);
    end
    wr_mem(9'h130, 18, 0); wait_done();
    rd_mem(9'h130, 3);
    chk(rbuf[0], 8'hB0, "R5 overwrite slot 0"); chk(rbuf[1], 8'hB1, "R5 overwrite slot 1");
    chk(rbuf[2], 8'hA2, "R5 slot 2 kept");

    cmd1(8'h06); wdat[0] = 8'h5A; wr_mem(9'h055, 1, 3);
    rd_stat(st); chk(st, 8'h02, "R6 stray bits discard");
    rd_mem(9'h055, 1); chk(rbuf[0], model[9'h055], "R6 data unchanged");
    wr_mem(9'h055, 0, 0);
    rd_stat(st); chk(st, 8'h02, "R6 no data byte discard");
    cmd1(8'h04);

    wdat[0] = 8'h66; wr_mem(9'h055, 1, 0);
    rd_stat(st); chk(st, 8'h00, "R7 latch clear blocks");
    cmd1(8'h06); wp_n = 0; wclk(8); wr_mem(9'h055, 1, 0); wp_n = 1; wclk(8);
    rd_stat(st); chk(st, 8'h02, "R7 protect pin blocks");
    rd_mem(9'h055, 1); chk(rbuf[0], model[9'h055], "R7 data unchanged");

    sel(); xfer(8'h02, dummy); xfer(8'h55, dummy); xfer(8'h99, dummy);
    wp_n = 0; wclk(8); wp_n = 1; wclk(8); desel();
    rd_stat(st); chk(st, 8'h02, "R9 pulse cancels write");
    rd_mem(9'h055, 1); chk(rbuf[0], model[9'h055], "R9 data unchanged");
    wdat[0] = 8'h77; wr_mem(9'h055, 1, 0); wp_n = 0; model[9'h055] = 8'h77;
    rd_stat(st); chk(st, 8'h03, "R9 cycle runs with pin low");
    wait_done(); wp_n = 1; wclk(8);
    rd_mem(9'h055, 1); chk(rbuf[0], 8'h77, "R9 write completed");

    set_stat(8'h04); rd_stat(st); chk(st, 8'h04, "R11 guard quarter");
    try_wr(9'h180, 8'h01, 0, "R8 quarter blocks 180");
    try_wr(9'h1FF, 8'h02, 0, "R8 quarter blocks 1FF");
    try_wr(9'h17F, 8'h03, 1, "R8 quarter allows 17F");
    set_stat(8'h08);
    try_wr(9'h100, 8'h04, 0, "R8 half blocks 100");
    try_wr(9'h0FF, 8'h05, 1, "R8 half allows 0FF");
    set_stat(8'h0C);
    try_wr(9'h000, 8'h06, 0, "R8 all blocks 000");
    set_stat(8'h30); rd_stat(st); chk(st, 8'h30, "R11 select field and guard off");
    try_wr(9'h1A3, 8'h07, 1, "R8 none allows 1A3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule